// File: doc/BRIEF.md
# Atomic 64-bit Compare-Exchange Unit

This block carries out the memory side of a complex read-modify-write instruction: an atomic 64-bit compare-and-swap. When it is started, it captures the following:
- an expected value, supplied as a high and a low 32-bit half;
- a 64-bit replacement value;
- an address;
- a flag saying whether the destination operand is memory;
- a flag saying whether a lock prefix was present.

For a memory destination, it reads the addressed word over a request/ready port whose read data returns after a variable delay. It then compares that word with `{exp_hi, exp_lo}`. On a match it writes the replacement value back and sets the equal flag. On a mismatch it leaves memory alone, clears the equal flag and loads the word it read into the expected-value halves.

A register destination is an illegal form, with or without a lock prefix. The unit answers it with a one-cycle invalid-opcode pulse. It makes no memory access, does not raise the bus lock, and returns to idle at once, so the illegal form can never freeze the machine.

With a lock prefix on a memory form, the unit holds a bus-lock output from the first read request until the write completes or the mismatch is resolved. The lock is always low in the cycle that the done pulse appears.

Top module: `cmpxchg_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fault_o`, `lock_o` and `mem_req_o` are all 0.
- R2: For a memory form whose read word equals `{exp_hi_i, exp_lo_i}` (high half in bits 63:32), the unit writes `swap_val_i` to the same address. It then pulses `done_o` with `equal_o`=1, and `exp_hi_o`/`exp_lo_o` equal the given halves.
- R3: For a memory form whose read word differs, no write is issued. `done_o` pulses with `equal_o`=0, and `exp_hi_o`=word[63:32] and `exp_lo_o`=word[31:0].
- R4: A register form (`is_mem_i`=0) without lock prefix gives exactly one `fault_o` pulse and no `done_o`. No memory request is made, and `busy_o` drops the cycle after the pulse.
- R5: A register form with `lock_pfx_i`=1 also gives exactly one `fault_o` pulse, makes no memory request, and never raises `lock_o`.
- R6: For a locked memory form, `lock_o` is 1 in every cycle from the first read request until the last cycle before `done_o`, and is 0 while `done_o` is high. An unlocked form never raises `lock_o`.
- R7: A request is held, with its direction unchanged, until `mem_ready_i`. After a read is accepted, the unit waits any number of cycles for `mem_rvalid_i` and issues no write before it.
- R8: `start_i` while `busy_o`=1 is ignored; the running operation completes with its captured operands.
- R9: Each memory-form operation produces exactly one single-cycle `done_o` pulse, and `done_o` and `fault_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (ignored while busy) |
| is_mem_i | input | 1 | 1: destination is memory, 0: register (illegal) |
| lock_pfx_i | input | 1 | Lock prefix present |
| addr_i | input | ADDR_W | Word address of the operand |
| exp_hi_i | input | HALF_W | Expected value, high half |
| exp_lo_i | input | HALF_W | Expected value, low half |
| swap_val_i | input | 2*HALF_W | Replacement value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse for memory forms |
| fault_o | output | 1 | One-cycle invalid-opcode pulse |
| equal_o | output | 1 | Equal/zero flag of the last compare |
| exp_hi_o | output | HALF_W | Updated expected value, high half |
| exp_lo_o | output | HALF_W | Updated expected value, low half |
| lock_o | output | 1 | Bus lock held for locked memory forms |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Request address |
| mem_wdata_o | output | 2*HALF_W | Write data |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 2*HALF_W | Read data |

## Verification
The hardest situation to reach is the locked sequence being stretched at every point where it can wait: a read request that is refused for several cycles, then a read reply that arrives late, then a write that is refused again. The lock must stay up through all of it and still fall exactly when done appears. The bench memory model draws acceptance and reply delay afresh each cycle from a random source. A batch of locked and unlocked operations, matching and missing, is run through it so that these stalls combine in many ways. A `start_i` pulse carrying different operands is also injected mid-operation, to show that an in-flight sequence cannot be disturbed.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_READ,
    ST_COMPARE,
    ST_WRITE,
    ST_DONE,
    ST_FAULT
  } cx_state_e;
endpackage

// File: rtl/cx_form_chk.sv
module cx_form_chk (
  input  logic is_mem_i,
  input  logic lock_pfx_i,
  output logic illegal_o,
  output logic lock_req_o
);
  // register destination is illegal regardless of prefix
  assign illegal_o  = !is_mem_i;
  assign lock_req_o = lock_pfx_i && is_mem_i;
endmodule

// File: rtl/cx_dp.sv
module cx_dp #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic                rd_cap_i,
  input  logic                cmp_i,
  input  logic [HALF_W-1:0]   exp_hi_i,
  input  logic [HALF_W-1:0]   exp_lo_i,
  input  logic [2*HALF_W-1:0] swap_val_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*HALF_W-1:0] rdata_i,
  output logic [HALF_W-1:0]   exp_hi_o,
  output logic [HALF_W-1:0]   exp_lo_o,
  output logic [2*HALF_W-1:0] swap_q_o,
  output logic [ADDR_W-1:0]   addr_q_o,
  output logic                match_o,
  output logic                equal_o
);
  localparam int unsigned WORD_W = 2 * HALF_W;

  logic [HALF_W-1:0] hi_q, lo_q;
  logic [WORD_W-1:0] rd_q, swap_q;
  logic [ADDR_W-1:0] addr_q;
  logic              eq_q;

  assign match_o = (rd_q == {hi_q, lo_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      rd_q   <= '0;
      swap_q <= '0;
      addr_q <= '0;
      eq_q   <= 1'b0;
    end else begin
      if (cap_i) begin
        hi_q   <= exp_hi_i;
        lo_q   <= exp_lo_i;
        swap_q <= swap_val_i;
        addr_q <= addr_i;
      end
      if (rd_cap_i) rd_q <= rdata_i;
      if (cmp_i) begin
        eq_q <= match_o;
        if (!match_o) begin
          hi_q <= rd_q[WORD_W-1:HALF_W];
          lo_q <= rd_q[HALF_W-1:0];
        end
      end
    end
  end

  assign exp_hi_o = hi_q;
  assign exp_lo_o = lo_q;
  assign swap_q_o = swap_q;
  assign addr_q_o = addr_q;
  assign equal_o  = eq_q;

  AST_HIT_KEEPS_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && match_o) |=> ($stable(exp_hi_o) && $stable(exp_lo_o) && equal_o)); // R2
  AST_MISS_LOADS_EXP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_i && !match_o) |=> ({exp_hi_o, exp_lo_o} == $past(rd_q) && !equal_o)); // R3
endmodule

// File: rtl/cx_seq.sv
module cx_seq
  import cx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic illegal_i,
  input  logic lock_req_i,
  input  logic match_i,
  input  logic mem_ready_i,
  input  logic mem_rvalid_i,
  output logic cap_o,
  output logic rd_cap_o,
  output logic cmp_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic lock_o,
  output logic busy_o,
  output logic done_o,
  output logic fault_o
);
  cx_state_e state_q, state_d;
  logic      illegal_q, lock_q, rd_acc_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_CHECK;
      ST_CHECK:   state_d = illegal_q ? ST_FAULT : ST_READ;
      ST_READ:    if (rd_acc_q && mem_rvalid_i) state_d = ST_COMPARE;
      ST_COMPARE: state_d = match_i ? ST_WRITE : ST_DONE;
      ST_WRITE:   if (mem_ready_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      ST_FAULT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      illegal_q <= 1'b0;
      lock_q    <= 1'b0;
      rd_acc_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_o) begin
        illegal_q <= illegal_i;
        lock_q    <= lock_req_i;
      end
      if (state_q != ST_READ) rd_acc_q <= 1'b0;
      else if (mem_ready_i)   rd_acc_q <= 1'b1;
    end
  end

  assign cap_o     = (state_q == ST_IDLE) && start_i;
  assign rd_cap_o  = (state_q == ST_READ) && rd_acc_q && mem_rvalid_i;
  assign cmp_o     = (state_q == ST_COMPARE);
  assign mem_req_o = ((state_q == ST_READ) && !rd_acc_q) || (state_q == ST_WRITE);
  assign mem_we_o  = (state_q == ST_WRITE);
  assign lock_o    = lock_q && ((state_q == ST_READ) || (state_q == ST_COMPARE) ||
                                (state_q == ST_WRITE));
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign fault_o   = (state_q == ST_FAULT);

  AST_FAULT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!lock_o && !mem_req_o && $past(!mem_req_o))); // R5
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_we_o))); // R7
  AST_LOCK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> (lock_o || done_o)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_XOR_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)); // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |-> !cap_o); // R8
endmodule

// File: rtl/cmpxchg_unit.sv
module cmpxchg_unit #(
  parameter int unsigned HALF_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                is_mem_i,
  input  logic                lock_pfx_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [HALF_W-1:0]   exp_hi_i,
  input  logic [HALF_W-1:0]   exp_lo_i,
  input  logic [2*HALF_W-1:0] swap_val_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                fault_o,
  output logic                equal_o,
  output logic [HALF_W-1:0]   exp_hi_o,
  output logic [HALF_W-1:0]   exp_lo_o,
  output logic                lock_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*HALF_W-1:0] mem_wdata_o,
  input  logic                mem_ready_i,
  input  logic                mem_rvalid_i,
  input  logic [2*HALF_W-1:0] mem_rdata_i
);
  logic illegal, lock_req, cap, rd_cap, cmp, match;

  cx_form_chk i_form (
    .is_mem_i   (is_mem_i),
    .lock_pfx_i (lock_pfx_i),
    .illegal_o  (illegal),
    .lock_req_o (lock_req)
  );

  cx_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .illegal_i    (illegal),
    .lock_req_i   (lock_req),
    .match_i      (match),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .cap_o        (cap),
    .rd_cap_o     (rd_cap),
    .cmp_o        (cmp),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .lock_o       (lock_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .fault_o      (fault_o)
  );

  cx_dp #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) i_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .rd_cap_i   (rd_cap),
    .cmp_i      (cmp),
    .exp_hi_i   (exp_hi_i),
    .exp_lo_i   (exp_lo_i),
    .swap_val_i (swap_val_i),
    .addr_i     (addr_i),
    .rdata_i    (mem_rdata_i),
    .exp_hi_o   (exp_hi_o),
    .exp_lo_o   (exp_lo_o),
    .swap_q_o   (mem_wdata_o),
    .addr_q_o   (mem_addr_o),
    .match_o    (match),
    .equal_o    (equal_o)
  );

  AST_WRITE_ONLY_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> equal_o); // R2
  AST_MISS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !equal_o) |-> $past(!mem_we_o)); // R3
  AST_LOCK_OFF_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> !lock_o); // R6
endmodule

// File: tb/test_cmpxchg_unit.sv
`timescale 1ns/1ps
module test_cmpxchg_unit;
  localparam int HW = 32;
  localparam int AW = 4;
  localparam int WW = 2 * HW;

  typedef struct {
    logic          fault;
    logic          eq;
    logic [HW-1:0] hi;
    logic [HW-1:0] lo;
    logic [AW-1:0] addr;
    logic [WW-1:0] mem_after;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, is_mem = 1'b0, lock_pfx = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [HW-1:0] exp_hi = '0, exp_lo = '0;
  logic [WW-1:0] swap_val = '0;
  logic busy, done, fault, equal, lock, mem_req, mem_we;
  logic [HW-1:0] ehi, elo;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [WW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  cmpxchg_unit #(.HALF_W(HW), .ADDR_W(AW)) i_cmpxchg_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_mem_i(is_mem),
    .lock_pfx_i(lock_pfx), .addr_i(addr), .exp_hi_i(exp_hi), .exp_lo_i(exp_lo),
    .swap_val_i(swap_val), .busy_o(busy), .done_o(done), .fault_o(fault),
    .equal_o(equal), .exp_hi_o(ehi), .exp_lo_o(elo), .lock_o(lock),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata)
  );

  int total = 0, bad = 0;
  item_t sb[$];
  logic [WW-1:0] mem [16];
  logic rd_pend = 1'b0;
  int rd_cnt = 0;
  logic [AW-1:0] rd_addr = '0;

  // memory model: random acceptance and read latency
  always @(posedge clk) begin
    mem_ready  <= ($urandom % 3) != 0;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_ready) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else begin
        rd_pend <= 1'b1;
        rd_cnt  <= int'($urandom % 5);
        rd_addr <= mem_addr;
      end
    end
    if (rd_pend) begin
      if (rd_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[rd_addr];
        rd_pend    <= 1'b0;
      end else rd_cnt <= rd_cnt - 1;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // per-operation observation state
  logic cur_lock = 1'b0, cur_fault = 1'b0;
  logic lock_err = 1'b0, req_seen = 1'b0, wr_seen = 1'b0;
  int   end_pulses = 0;

  // monitor: scoreboard and lock tracking
  always @(negedge clk) begin
    if (rst_n) begin
      if (lock && !cur_lock) lock_err = 1'b1;
      if (cur_lock && mem_req && !mem_we && !lock) lock_err = 1'b1;
      if (lock && (done || fault)) lock_err = 1'b1;
      if (mem_req) req_seen = 1'b1;
      if (mem_req && mem_we) wr_seen = 1'b1;
      if (done || fault) begin
        item_t it;
        end_pulses++;
        if (sb.size() == 0) check("R9", "unexpected end pulse", 1, 0);
        else begin
          it = sb.pop_front();
          if (it.fault) begin
            check(cur_lock ? "R5" : "R4", "fault pulse", {63'd0, fault}, 64'd1);
            check(cur_lock ? "R5" : "R4", "no done", {63'd0, done}, 64'd0);
            check(cur_lock ? "R5" : "R4", "no mem request", {63'd0, req_seen}, 64'd0);
          end else begin
            check("R9", "done not fault", {62'd0, done, fault}, 64'd2);
            check(it.eq ? "R2" : "R3", "equal flag", {63'd0, equal}, {63'd0, it.eq});
            check(it.eq ? "R2" : "R3", "exp value", {ehi, elo}, {it.hi, it.lo});
            check(it.eq ? "R2" : "R3", "memory word", mem[it.addr], it.mem_after);
            if (!it.eq) check("R3", "no write", {63'd0, wr_seen}, 64'd0);
          end
          check("R6", "lock discipline", {63'd0, lock_err}, 64'd0);
        end
      end
    end
  end

  task automatic run_op(input logic m, input logic l, input logic [AW-1:0] a,
                        input logic [HW-1:0] h, input logic [HW-1:0] lw,
                        input logic [WW-1:0] nv, input logic poke);
    item_t it;
    it.fault = !m;
    it.addr  = a;
    it.eq    = m && (mem[a] == {h, lw});
    it.hi    = it.eq ? h : mem[a][WW-1:HW];
    it.lo    = it.eq ? lw : mem[a][HW-1:0];
    it.mem_after = it.eq ? nv : mem[a];
    @(negedge clk);
    cur_lock = l && m; cur_fault = !m;
    lock_err = 1'b0; req_seen = 1'b0; wr_seen = 1'b0; end_pulses = 0;
    sb.push_back(it);
    is_mem = m; lock_pfx = l; addr = a; exp_hi = h; exp_lo = lw; swap_val = nv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    is_mem = 1'b0; lock_pfx = 1'b1; addr = ~a; exp_hi = ~h; exp_lo = ~lw; swap_val = ~nv;
    if (poke) begin
      // R8: restart attempt with different operands while busy
      @(negedge clk);
      check("R8", "busy during op", {63'd0, busy}, 64'd1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    check("R9", "single end pulse", 64'(end_pulses), 64'd1);
    if (!m) check(l ? "R5" : "R4", "idle after fault", {63'd0, busy}, 64'd0);
    @(negedge clk);
    check("R8", "no extra op", {62'd0, busy, done}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = {32'h1000_0000 + 32'(i), 32'hA5A5_0000 + 32'(i * 7)};
    repeat (3) @(negedge clk);
    check("R1", "reset outputs", {59'd0, busy, done, fault, lock, mem_req}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {59'd0, busy, done, fault, lock, mem_req}, 64'd0);

    run_op(1, 1, 3, mem[3][63:32], mem[3][31:0], 64'hDEAD_BEEF_0123_4567, 0); // R2 locked hit
    run_op(1, 0, 5, 32'h0, 32'h1, 64'h1111, 0);                               // R3 miss
    run_op(0, 0, 7, 32'h5, 32'h6, 64'h2222, 0);                               // R4
    run_op(0, 1, 7, 32'h5, 32'h6, 64'h3333, 0);                               // R5
    run_op(1, 1, 3, mem[3][63:32], mem[3][31:0], 64'h4444, 0);                // R2 after write
    run_op(1, 1, 9, 32'h9, 32'h9, 64'h5555, 1);                               // R8 miss
    run_op(1, 0, 9, mem[9][63:32], mem[9][31:0], 64'h6666, 1);                // R8 hit
    for (int k = 0; k < 40; k++) begin : rand_ops                             // R7 stalls
      logic [AW-1:0] a = AW'($urandom % 16);
      logic hit = ($urandom % 2) == 1;
      logic mf  = ($urandom % 6) != 0;
      logic lk  = ($urandom % 2) == 1;
      run_op(mf, lk, a, hit ? mem[a][63:32] : 32'($urandom), hit ? mem[a][31:0] : 32'($urandom),
             {32'($urandom), 32'($urandom)}, ($urandom % 4) == 0);
    end
    check("R9", "scoreboard drained", 64'(sb.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule